// File: doc/BRIEF.md
# Complementary Code Keying Chip Modulator

This block turns payload words into 8-chip complementary code keying symbols for a spread-spectrum transmitter. In the low-rate mode each accepted word carries 4 bits (a nibble); in the high-rate mode it carries 8 bits. Two of the bits advance a running differential phase that is shared by all chips of a symbol. The remaining bits pick the code word: one of 4 in the low-rate mode, one of 64 in the high-rate mode. A fixed cover then rotates two chips of every symbol by half a turn.

Each chip is a QPSK point given as a 2-bit phase index in units of a quarter turn (0 = 0, 1 = π/2, 2 = π, 3 = 3π/2). Chips leave the block one per clock with a valid strobe. A valid/ready handshake accepts the next word in the cycle that shows the eighth chip, so a steady supply of words gives an unbroken chip stream. A frame-start pulse clears the phase reference and the symbol parity before the first payload symbol.

Top module: `cck_modulator`

## Requirements
- R1: While reset is held and in the first cycle after it, chip_valid is 0 and data_ready is 1.
- R2: A word is taken on a rising edge where data_valid and data_ready are both 1. Its 8 chips appear in the 8 cycles that follow, one per cycle, with chip_valid high. data_ready is 0 during chips 1 to 7 and 1 during chip 8. chip_valid falls after chip 8 unless a new word is taken on that edge.
- R3: The differential bits are data_in[0] (earlier) and data_in[1]. Written as (data_in[0],data_in[1]), they give a phase step on an even symbol of 00→0, 01→1, 11→2 and 10→3.
- R4: On an odd symbol the phase step from R3 is increased by 2, modulo 4.
- R5: The reference phase φ1 of a symbol is the previous symbol's φ1 plus its phase step, modulo 4. Chip 8 carries φ1 unchanged.
- R6: In the high-rate mode (rate_hi = 1), φ2 = 2·data_in[2] + data_in[3], φ3 = 2·data_in[4] + data_in[5] and φ4 = 2·data_in[6] + data_in[7]. Chip k (1 to 8) is φ1 plus φ2 if k is odd, plus φ3 if k is 1, 2, 5 or 6, and plus φ4 if k is 1 to 4, all modulo 4.
- R7: In the low-rate mode (rate_hi = 0), φ2 = 2·data_in[2] + 1, φ3 = 0 and φ4 = 2·data_in[3], with the chip rule of R6. data_in[7:4] has no effect.
- R8: Chips 4 and 7 receive an extra 2, modulo 4 (cover rotation).
- R9: frame_start sets the reference phase to 0 and the parity to even. A word taken on the same edge is the first symbol of the new frame: it is even and uses reference 0.
- R10: data_valid while data_ready is 0 is ignored: it neither adds chips nor moves the phase reference or the parity.
- R11: rate_hi and data_in are sampled only when a word is taken. Changing them during a symbol does not alter its chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears the phase reference and the parity |
| rate_hi | input | 1 | 1 = byte per symbol, 0 = nibble per symbol |
| data_in | input | 8 | Payload word, bit 0 earliest in time |
| data_valid | input | 1 | data_in holds a word |
| data_ready | output | 1 | A word can be taken on this edge |
| chip_valid | output | 1 | chip_phase holds a chip |
| chip_phase | output | 2 | Chip phase in quarter turns |

## Verification
A wrong phase reference or parity bit leaves every chip of the symbol shifted by the same amount, and the shift carries on into every later symbol until the next frame start. A run that compares all eight chips of each symbol therefore shows it in the first symbol after the fault, at chip 8 at the latest. A wrong code-word or cover term shifts only the chips that contain it, and it shows in the same symbol. A miscount in the chip sequencer shows up as a symbol with the wrong length, or as data_ready at the wrong chip, within at most nine cycles.

// File: rtl/cck_pkg.sv
package cck_pkg;

  localparam int WORD_W    = 8;
  localparam int PH_W      = 2;
  localparam int SYM_CHIPS = 8;
  localparam int CNT_W     = $clog2(SYM_CHIPS);
  localparam int COVER_A   = 3;   // zero-based chip index with half-turn cover
  localparam int COVER_B   = 6;

  typedef logic [PH_W-1:0]  phase_t;
  typedef logic [CNT_W-1:0] chip_idx_t;

  localparam phase_t HALF_TURN = phase_t'(2);

  // Differential step for an even symbol, first bit earlier in time
  function automatic phase_t step_of_dibit(input logic first, input logic second);
    phase_t s;
    unique case ({first, second})
      2'b00:   s = phase_t'(0);
      2'b01:   s = phase_t'(1);
      2'b11:   s = phase_t'(2);
      default: s = phase_t'(3);
    endcase
    return s;
  endfunction

  // Code phase from a bit pair, first bit weighted by two
  function automatic phase_t pair_phase(input logic first, input logic second);
    return {first, second};
  endfunction

endpackage

// File: rtl/cck_diff_phase.sv
module cck_diff_phase
  import cck_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_start,
  input  logic   accept,
  input  logic   bit_first,
  input  logic   bit_second,
  output phase_t phi1_next
);

  phase_t ref_q, ref_d;
  logic   odd_q, odd_d;
  phase_t base;
  logic   odd_eff;

  always_comb begin
    base      = frame_start ? phase_t'(0) : ref_q;
    odd_eff   = frame_start ? 1'b0 : odd_q;
    phi1_next = base + step_of_dibit(bit_first, bit_second)
              + (odd_eff ? HALF_TURN : phase_t'(0));
    ref_d     = ref_q;
    odd_d     = odd_q;
    if (accept) begin
      ref_d = phi1_next;
      odd_d = ~odd_eff;
    end else if (frame_start) begin
      ref_d = phase_t'(0);
      odd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      odd_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      odd_q <= odd_d;
    end
  end

endmodule

// File: rtl/cck_code_sel.sv
module cck_code_sel
  import cck_pkg::*;
(
  input  logic              rate_hi,
  input  logic [WORD_W-1:0] word,
  output phase_t            phi2,
  output phase_t            phi3,
  output phase_t            phi4
);

  always_comb begin
    if (rate_hi) begin
      phi2 = pair_phase(word[2], word[3]);
      phi3 = pair_phase(word[4], word[5]);
      phi4 = pair_phase(word[6], word[7]);
    end else begin
      phi2 = pair_phase(word[2], 1'b1);
      phi3 = phase_t'(0);
      phi4 = pair_phase(word[3], 1'b0);
    end
  end

endmodule

// File: rtl/cck_chip_seq.sv
module cck_chip_seq
  import cck_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      data_valid,
  output logic      data_ready,
  output logic      accept,
  output logic      busy,
  output chip_idx_t chip_idx
);

  localparam chip_idx_t LAST = chip_idx_t'(SYM_CHIPS - 1);

  logic      busy_q, busy_d;
  chip_idx_t cnt_q, cnt_d;

  always_comb begin
    data_ready = !busy_q || (cnt_q == LAST);
    accept     = data_valid && data_ready;
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_d = 1'b0;
      else               cnt_d  = cnt_q + chip_idx_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy     = busy_q;
  assign chip_idx = cnt_q;

endmodule

// File: rtl/cck_modulator.sv
module cck_modulator
  import cck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              rate_hi,
  input  logic [WORD_W-1:0] data_in,
  input  logic              data_valid,
  output logic              data_ready,
  output logic              chip_valid,
  output logic [PH_W-1:0]   chip_phase
);

  logic      accept;
  logic      busy;
  chip_idx_t chip_idx;
  phase_t    phi1_next, phi2_in, phi3_in, phi4_in;
  phase_t    phi1_q, phi2_q, phi3_q, phi4_q;
  phase_t    chip_arr [SYM_CHIPS];

  cck_chip_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_valid (data_valid),
    .data_ready (data_ready),
    .accept     (accept),
    .busy       (busy),
    .chip_idx   (chip_idx)
  );

  cck_diff_phase u_diff (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .accept      (accept),
    .bit_first   (data_in[0]),
    .bit_second  (data_in[1]),
    .phi1_next   (phi1_next)
  );

  cck_code_sel u_sel (
    .rate_hi (rate_hi),
    .word    (data_in),
    .phi2    (phi2_in),
    .phi3    (phi3_in),
    .phi4    (phi4_in)
  );

  // Symbol phases, loaded only when a word is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi1_q <= '0;
      phi2_q <= '0;
      phi3_q <= '0;
      phi4_q <= '0;
    end else if (accept) begin
      phi1_q <= phi1_next;
      phi2_q <= phi2_in;
      phi3_q <= phi3_in;
      phi4_q <= phi4_in;
    end
  end

  // Chip k holds phi2/phi3/phi4 when index bit 0/1/2 is clear
  for (genvar k = 0; k < SYM_CHIPS; k++) begin : g_chip
    localparam logic USE2  = ((k >> 0) & 1) == 0;
    localparam logic USE3  = ((k >> 1) & 1) == 0;
    localparam logic USE4  = ((k >> 2) & 1) == 0;
    localparam logic COVER = (k == COVER_A) || (k == COVER_B);
    always_comb begin
      chip_arr[k] = phi1_q
                  + (USE2  ? phi2_q    : phase_t'(0))
                  + (USE3  ? phi3_q    : phase_t'(0))
                  + (USE4  ? phi4_q    : phase_t'(0))
                  + (COVER ? HALF_TURN : phase_t'(0));
    end
  end

  assign chip_valid = busy;
  assign chip_phase = chip_arr[chip_idx];

endmodule

// File: rtl/cck_modulator_chk.sv
module cck_modulator_chk
  import cck_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              data_valid,
  input logic [WORD_W-1:0] data_in,
  input logic              data_ready,
  input logic              chip_valid,
  input logic [PH_W-1:0]   chip_phase,
  input logic [PH_W-1:0]   phi1_sym
);

  logic [CNT_W:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       seen_q <= '0;
    else if (data_valid && data_ready) seen_q <= '0;
    else if (chip_valid)              seen_q <= seen_q + 1'b1;
  end

  // R1: no chips without a symbol in flight keeps the block ready
  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid |-> data_ready);

  // R2: a taken word starts chips on the next cycle
  a_r2_start_chips: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_ready) |=> chip_valid);

  // R2: ready only on the eighth chip of a symbol
  a_r2_ready_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid |-> (data_ready == (seen_q == (CNT_W+1)'(SYM_CHIPS - 1))));

  // R2: symbol ends after the eighth chip when nothing new is taken
  a_r2_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && data_ready && !data_valid) |=> !chip_valid);

  // R10: a busy block keeps going regardless of data_valid
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !data_ready) |=> chip_valid);

  // R5: chip 8 carries the reference phase of the symbol
  a_r5_last_is_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && seen_q == (CNT_W+1)'(SYM_CHIPS - 1)) |-> (chip_phase == phi1_sym));

  // R9: frame start with a zero step gives reference zero
  a_r9_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && data_valid && data_ready && data_in[1:0] == 2'b00)
      |=> (phi1_sym == '0));

endmodule

bind cck_modulator cck_modulator_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .data_valid  (data_valid),
  .data_in     (data_in),
  .data_ready  (data_ready),
  .chip_valid  (chip_valid),
  .chip_phase  (chip_phase),
  .phi1_sym    (phi1_q)
);

// File: tb/test_cck_modulator.sv
`timescale 1ns/1ps
module test_cck_modulator;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start;
  logic       rate_hi;
  logic [7:0] data_in;
  logic       data_valid;
  logic       data_ready;
  logic       chip_valid;
  logic [1:0] chip_phase;

  int n_cmp = 0;
  int n_bad = 0;

  int exp_ref = 0;
  bit exp_odd = 1'b0;

  always #2.5 clk = ~clk;

  cck_modulator i_cck_modulator (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .rate_hi     (rate_hi),
    .data_in     (data_in),
    .data_valid  (data_valid),
    .data_ready  (data_ready),
    .chip_valid  (chip_valid),
    .chip_phase  (chip_phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // R3 even step map on (d0,d1)
  function automatic int step_of(input bit d0, input bit d1);
    case ({d0, d1})
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  // Word must already be driven at the current negedge
  task automatic do_sym(input logic [7:0] w, input bit r, input bit fs,
                        input bit poke, input bit chain,
                        input logic [7:0] nw, input bit nr);
    int p1, p2, p3, p4, st;
    int ex [8];
    chk(data_ready === 1'b1, "R2 ready before take", int'(data_ready), 1);
    if (fs) begin
      exp_ref = 0;
      exp_odd = 1'b0;
    end
    st = step_of(w[0], w[1]) + (exp_odd ? 2 : 0);            // R3 R4
    p1 = (exp_ref + st) % 4;                                  // R5
    exp_ref = p1;
    exp_odd = !exp_odd;
    if (r) begin                                              // R6
      p2 = 2*w[2] + w[3];
      p3 = 2*w[4] + w[5];
      p4 = 2*w[6] + w[7];
    end else begin                                            // R7
      p2 = 2*w[2] + 1;
      p3 = 0;
      p4 = 2*w[3];
    end
    for (int k = 0; k < 8; k++) begin
      ex[k] = p1 + ((k % 2 == 0) ? p2 : 0) + (((k / 2) % 2 == 0) ? p3 : 0)
            + ((k < 4) ? p4 : 0) + ((k == 3 || k == 6) ? 2 : 0); // R8
      ex[k] = ex[k] % 4;
    end
    @(posedge clk);
    @(negedge clk);
    data_valid  = 1'b0;
    frame_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (poke && k < 6) begin                                // R10 R11
        data_valid = 1'b1;
        data_in    = ~w;
        rate_hi    = ~r;
      end
      if (poke && k == 6) data_valid = 1'b0;
      chk(chip_valid === 1'b1, "R2 chip_valid", int'(chip_valid), 1);
      chk(int'(chip_phase) == ex[k],
          (k == 3 || k == 6) ? "R8 cover chip" : (k == 7 ? "R5 chip8" : "R6 R7 chip"),
          int'(chip_phase), ex[k]);
      chk(data_ready === (k == 7), "R2 ready timing", int'(data_ready), int'(k == 7));
      if (k == 7 && chain) begin
        data_in    = nw;
        rate_hi    = nr;
        data_valid = 1'b1;
      end
      if (k < 7) @(negedge clk);
    end
    if (!chain) begin
      @(negedge clk);
      chk(chip_valid === 1'b0, "R2 stop after chip8", int'(chip_valid), 0);
    end
  endtask

  task automatic send(input logic [7:0] w, input bit r, input bit fs, input bit poke);
    @(negedge clk);
    data_in     = w;
    rate_hi     = r;
    frame_start = fs;
    data_valid  = 1'b1;
    do_sym(w, r, fs, poke, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic pulse_fs();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    exp_ref = 0;
    exp_odd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    frame_start = 1'b0;
    rate_hi     = 1'b0;
    data_in     = 8'h00;
    data_valid  = 1'b0;
    repeat (3) @(negedge clk);
    chk(chip_valid === 1'b0, "R1 valid in reset", int'(chip_valid), 0);
    chk(data_ready === 1'b1, "R1 ready in reset", int'(data_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chip_valid === 1'b0, "R1 valid after reset", int'(chip_valid), 0);
    chk(data_ready === 1'b1, "R1 ready after reset", int'(data_ready), 1);

    // R6 R3 R4: every byte in high-rate mode, one frame
    for (int i = 0; i < 256; i++) send(8'(i), 1'b1, i == 0, 1'b0);

    // R7: every nibble in low-rate mode with varied upper bits
    for (int i = 0; i < 16; i++) send(8'((i * 37 + 5) << 4 | i), 1'b0, i == 0, 1'b0);

    // R9: frame start alone, then step 0 must give reference 0
    pulse_fs();
    send(8'hE4, 1'b1, 1'b0, 1'b0);
    send(8'h5B, 1'b1, 1'b0, 1'b0);
    // R9: frame start on the same edge as a taken word
    send(8'h3A, 1'b1, 1'b1, 1'b0);
    send(8'hC2, 1'b0, 1'b0, 1'b0);

    // R10 R11: inputs toggled while busy must not matter
    send(8'h96, 1'b1, 1'b0, 1'b1);
    send(8'h2D, 1'b0, 1'b0, 1'b1);
    send(8'h71, 1'b1, 1'b0, 1'b0);

    // R2: back-to-back chain, mixed rates
    @(negedge clk);
    data_in = 8'h1F; rate_hi = 1'b1; frame_start = 1'b1; data_valid = 1'b1;
    do_sym(8'h1F, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA6, 1'b0);
    do_sym(8'hA6, 1'b0, 1'b0, 1'b0, 1'b1, 8'h53, 1'b1);
    do_sym(8'h53, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1);
    do_sym(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule